// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into the two timing strobes a serial transmitter and receiver need. The strobes are a one-cycle oversample tick at sixteen times the bit rate, and a bit tick that marks every sixteenth oversample tick. The rate comes from a 16-bit divider word. The upper twelve bits of the word are the whole number of clock cycles per oversample tick. The lower four bits add a fraction in sixteenths.

A fractional divider cannot be met by one fixed interval. The generator therefore makes some tick intervals one cycle longer than the whole part, using a small running remainder, so that sixteen ticks take exactly sixteen times the divider. For example, with a 72 MHz clock and 9600 baud the divider is 468.75, which is written as 0x1D4C.

The divider is a plain level input taken from a configuration register. Any change to it is detected inside the block and restarts the timing from a clean state. The enable input is also a plain control pin. The outputs are bare strobes with no handshake.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `os_tick` and `bit_tick` are low. The stored divider copy resets to zero.
- R2: `div_val[15:4]` is the mantissa M and `div_val[3:0]` is the fraction F in sixteenths. With F = 0 and M >= 1, consecutive `os_tick` pulses are exactly M cycles apart.
- R3: With F != 0, a 4-bit remainder starts at 0 and gains F on every oversample tick, wrapping modulo 16. An interval lasts M+1 cycles when adding F to the remainder overflows 15, and M cycles otherwise. Sixteen ticks therefore span 16*M + F cycles.
- R4: `bit_tick` is high only together with `os_tick`. It fires on the 16th, 32nd, and so on oversample tick counted since the last restart.
- R5: When M = 0 (a divider below 1.0, including zero), no tick of either kind is produced.
- R6: While `en` is low, no tick is produced, and the counter, remainder and bit phase are cleared. After `en` rises, the first tick comes in the cycle whose index from the rise is M-1 (or M when F carries).
- R7: In the first cycle that `div_val` differs from the stored copy, no tick is produced. The counter, remainder and bit phase are cleared in that cycle, so the next tick arrives M (or M+1) cycles later.
- R8: With M >= 2, `os_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Tick generation enable |
| div_val | input | 16 | Divider word: mantissa in 15:4, sixteenths in 3:0 |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle strobe on every 16th oversample tick |

## Verification
The hardest case to reach is a bit tick that lands on a stretched interval while the remainder wraps, and then a divider change in the middle of a frame. The change must wipe the counter, the remainder and the bit phase all at once. The stimulus first runs a 1.5 divider, whose intervals alternate between one and two cycles, through a full sixteen-tick frame. It then runs the 468.75 divider across a whole frame of 7500 cycles. Finally it rewrites the divider part-way into a frame and counts the ticks in a window measured from the rewrite. A behavioural reference is compared on every clock throughout.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int DIV_W_DEF   = 16;
  localparam int FRAC_W_DEF  = 4;
  localparam int PHASE_W_DEF = 4;

  function automatic logic mant_nonzero(input logic [DIV_W_DEF-FRAC_W_DEF-1:0] m);
    return |m;
  endfunction
endpackage

// File: rtl/brg_frac_acc.sv
module brg_frac_acc #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (adv)      acc_q <= sum[FRAC_W-1:0];
  end

  // R3: a zero fraction never moves the remainder away from zero
  assert_zero_frac_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || (frac == '0 && acc_q == '0)) |=> (acc_q == '0 || $past(frac) != '0));
endmodule

// File: rtl/brg_period_cnt.sv
module brg_period_cnt #(
  parameter int MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [MANT_W-1:0] mant,
  input  logic              stretch,
  output logic              tick
);
  logic [MANT_W-1:0] cnt_q;
  logic              last;

  assign last = stretch ? (cnt_q == mant) : (cnt_q == mant - MANT_W'(1));
  assign tick = run && last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (last)      cnt_q <= '0;
    else                cnt_q <= cnt_q + MANT_W'(1);
  end

  // R3: the count never runs past the stretched interval length
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= mant));
endmodule

// File: rtl/brg_bit_phase.sv
module brg_bit_phase #(
  parameter int PHASE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic wrap
);
  logic [PHASE_W-1:0] ph_q;

  assign wrap = adv && (&ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ph_q <= '0;
    else if (adv)      ph_q <= ph_q + PHASE_W'(1);
  end

  // R4: the phase only moves on an oversample tick
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ph_q));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W   = brg_pkg::DIV_W_DEF,
  parameter int FRAC_W  = brg_pkg::FRAC_W_DEF,
  parameter int PHASE_W = brg_pkg::PHASE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             os_tick,
  output logic             bit_tick
);
  localparam int MANT_W = DIV_W - FRAC_W;

  logic [DIV_W-1:0]  div_q;
  logic [MANT_W-1:0] mant;
  logic [FRAC_W-1:0] frac;
  logic              chg, run, stretch, tick;

  assign mant = div_val[DIV_W-1:FRAC_W];
  assign frac = div_val[FRAC_W-1:0];
  assign chg  = (div_val != div_q);
  assign run  = rst_n && en && (|mant) && !chg;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_val;
  end

  brg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(!run), .adv(tick), .frac(frac), .carry(stretch)
  );

  brg_period_cnt #(.MANT_W(MANT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .mant(mant), .stretch(stretch), .tick(tick)
  );

  brg_bit_phase #(.PHASE_W(PHASE_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .clr(!run), .adv(tick), .wrap(bit_tick)
  );

  assign os_tick = tick;

  assert_bit_with_os_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  assert_quiet_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !os_tick);
  assert_quiet_below_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val[DIV_W-1:FRAC_W] == '0) |-> !os_tick);
  assert_quiet_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val != $past(div_val)) |-> !os_tick);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && div_val[DIV_W-1:FRAC_W+1] != '0) |=> !os_tick);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div_val = 16'h0000;
  logic        os_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  int m_cnt = 0, m_rem = 0, m_ph = 0;
  int m_prev = 0;

  always @(negedge clk) begin
    int mant, frac, per;
    logic e_os, e_bit;
    mant = int'(div_val) >> 4;
    frac = int'(div_val) & 15;
    e_os = 1'b0; e_bit = 1'b0;
    if (!rst_n) begin
      m_cnt = 0; m_rem = 0; m_ph = 0; m_prev = 0;
    end else if (int'(div_val) != m_prev) begin
      m_prev = int'(div_val);
      m_cnt = 0; m_rem = 0; m_ph = 0;
    end else if (!en || mant == 0) begin
      m_cnt = 0; m_rem = 0; m_ph = 0;
    end else begin
      per = mant + ((m_rem + frac >= 16) ? 1 : 0);
      if (m_cnt == per - 1) begin
        e_os = 1'b1;
        e_bit = (m_ph == 15);
        m_cnt = 0;
        m_rem = (m_rem + frac) % 16;
        m_ph = (m_ph + 1) % 16;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    checks++;
    if (os_tick !== e_os || bit_tick !== e_bit) begin
      errors++;
      $display("FAIL %s cycle compare: os=%b bit=%b expected os=%b bit=%b",
               cur_req, os_tick, bit_tick, e_os, e_bit);
    end
  end

  task automatic check_eq(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // apply inputs just after an edge, then count strobes over n cycles
  task automatic window(input logic [15:0] d, input logic e, input int n,
                        input int exp_os, input int exp_bit, input string req);
    int c_os = 0, c_bit = 0;
    @(posedge clk); #1;
    div_val = d; en = e; cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (os_tick) c_os++;
      if (bit_tick) c_bit++;
    end
    check_eq(req, c_os, exp_os, "oversample tick count");
    check_eq(req, c_bit, exp_bit, "bit tick count");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low
    div_val = 16'h0030; en = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", int'(os_tick), 0, "os_tick in reset");
    check_eq("R1", int'(bit_tick), 0, "bit_tick in reset");
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", int'(os_tick), 0, "os_tick first cycle after reset");
    repeat (10) @(negedge clk);

    // R2 / R4: integer divider 3, restart then 16 ticks in 49 cycles
    window(16'h0050, 1'b1, 1, 0, 0, "R7");
    window(16'h0030, 1'b1, 49, 16, 1, "R2");
    // R3: divider 1.5 alternates 1 and 2 cycle gaps, 16 ticks in 25 cycles
    window(16'h0018, 1'b1, 25, 16, 1, "R3");
    window(16'h0018, 1'b1, 48, 32, 2, "R4");
    // R3: 468.75 -> one frame spans 7500 cycles after the restart cycle
    window(16'h1D4C, 1'b1, 7501, 16, 1, "R3");
    // R5: below 1.0 and zero
    window(16'h000F, 1'b1, 200, 0, 0, "R5");
    window(16'h0000, 1'b1, 200, 0, 0, "R5");
    // R6: disabled, then re-enabled from clean state
    window(16'h0030, 1'b1, 20, 6, 0, "R6");
    window(16'h0030, 1'b0, 50, 0, 0, "R6");
    window(16'h0030, 1'b1, 48, 16, 1, "R6");
    // R7: change part-way into a frame, divider 5 -> 16 ticks in 81 cycles
    window(16'h0030, 1'b1, 17, 5, 0, "R7");
    window(16'h0050, 1'b1, 81, 16, 1, "R7");
    // R8: divider 2.9375, no back-to-back pulses, compared every cycle
    window(16'h002F, 1'b1, 300, 102, 6, "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule